// File: doc/BRIEF.md
# Memory-to-Memory Copy Channel Pair

This block is a register-programmed copy engine built from a reading channel and a writing channel. Each channel owns its own address walker: a start address, an element count per row, a signed byte step between elements and, when two-dimensional mode is on, a row count and a signed byte step applied at the end of each row. Software fills these fields over a simple write bus. It then turns on both channels. Elements of 8, 16 or 32 bits are read from a source memory port, held in a four-entry element buffer, and written to a destination memory port.

Completion is reported by sticky flags that software clears by writing ones. The writing channel raises a one-cycle interrupt pulse when it sets its done flag. A mismatched or reserved element width, or an address that is not aligned to the element size, sets an error flag on both channels and halts all memory traffic. Writing a configuration word with the buffer-clear bit set stops that channel and empties the element buffer.

Top module: `dma_pair`

## Requirements
- R1: After reset every register reads zero and no memory port or interrupt is active. Register address bit 3 picks the channel (0 reading, 1 writing). Bits 2:0 pick the field: 0 start address, 1 row element count, 2 element step, 3 row count, 4 row step, 5 config, 6 status. Written values read back unchanged, except config bit 7, which reads zero.
- R2: Config bit 0 enables the channel. Bits 4:3 give the element width (0 = 8, 1 = 16, 2 = 32 bits, 3 reserved). Nothing moves until both channels are enabled. A one-dimensional copy then moves count elements, each element read at the source address and written unchanged at the destination address, with widths in the low bits of the 32-bit data buses.
- R3: A negative element step (two's complement) walks addresses downward.
- R4: With config bit 2 set, the element step is added after every element except the last of a row. The row step is added after the last element of a row. The copy covers row-count rows of count elements.
- R5: Status bit 0 (done) is set on the writing channel in the cycle after its last element is written. It is set on the reading channel after its last read is issued. Status bits 0 and 1 are cleared only by writing a one to them.
- R6: The interrupt pulses for one cycle together with the writing channel's done flag. This happens when config bit 5 is set in one-dimensional mode, or when config bit 6 is set in two-dimensional mode. In two-dimensional mode with bit 5 set, it pulses after the last element of each row.
- R7: Differing element widths on the two enabled channels, or the reserved width, set status bit 1 (error) on both channels with no memory access.
- R8: A current address not aligned to the element size sets the error flag on both channels and stops the copy before that access.
- R9: Writing a config word with bit 7 set clears that channel's enable, empties the element buffer and stops all further transfers; a later copy moves fresh data only.
- R10: Reads never run more than the buffer depth plus one in-flight read ahead of writes, and a write happens only when the buffer holds an element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Channel select (bit 3) and field select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| srcRe | output | 1 | Source read request |
| srcAddr | output | ADDR_W | Source byte address |
| srcSize | output | 2 | Source element width code |
| srcRdata | input | 32 | Source data, valid the cycle after srcRe |
| dstWe | output | 1 | Destination write strobe |
| dstAddr | output | ADDR_W | Destination byte address |
| dstSize | output | 2 | Destination element width code |
| dstWdata | output | 32 | Destination write data, element in low bits |
| dmaIrq | output | 1 | One-cycle completion interrupt pulse |

## Verification
The embedded properties watch, cycle by cycle, the following:
- the buffer level stays within its depth;
- writes only drain a non-empty buffer;
- no port is active while an error flag is set;
- source addresses are aligned;
- the buffer is empty after a clear;
- the done flag rises only after a write, with the interrupt alongside it.

Only the scenarios show the rest:
- the actual address sequences of upward, downward and two-dimensional walks, against a byte-addressed memory model and a queue of expected writes;
- the per-row interrupt count;
- write-one-to-clear behaviour;
- the absence of stale data after an aborted copy.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int DATA_W = 32;

  localparam logic [2:0] RG_START = 3'd0;
  localparam logic [2:0] RG_XCNT  = 3'd1;
  localparam logic [2:0] RG_XMOD  = 3'd2;
  localparam logic [2:0] RG_YCNT  = 3'd3;
  localparam logic [2:0] RG_YMOD  = 3'd4;
  localparam logic [2:0] RG_CFG   = 3'd5;
  localparam logic [2:0] RG_STAT  = 3'd6;

  localparam int CF_EN   = 0;
  localparam int CF_WNR  = 1;
  localparam int CF_2D   = 2;
  localparam int CF_WLO  = 3;
  localparam int CF_IRQX = 5;
  localparam int CF_IRQY = 6;
  localparam int CF_CLR  = 7;

  localparam logic [1:0] EW_RSV = 2'd3;

  typedef struct packed {
    logic srcIssue;
    logic dstWrite;
    logic srcDoneSet;
    logic dstDoneSet;
    logic errSet;
    logic irqSet;
  } dmaStrobeT;

  typedef struct packed {
    logic       srcEn;
    logic       dstEn;
    logic       srcDone;
    logic       dstDone;
    logic       srcErr;
    logic       dstErr;
    logic [1:0] srcWidth;
    logic [1:0] dstWidth;
    logic [1:0] srcLow;
    logic [1:0] dstLow;
    logic       srcLast;
    logic       dstLast;
    logic       dstRowEnd;
    logic       dst2D;
    logic       dstIrqX;
    logic       dstIrqY;
    logic       rdPend;
  } dmaStatusT;

  function automatic logic [1:0] alignMask(input logic [1:0] w);
    case (w)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] elemMask(input logic [1:0] w);
    case (w)
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

endpackage

// File: rtl/dma_walker.sv
module dma_walker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              step,
  input  logic              mode2D,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  xCount,
  input  logic [CNT_W-1:0]  yCount,
  input  logic [CNT_W-1:0]  xMod,
  input  logic [CNT_W-1:0]  yMod,
  output logic [ADDR_W-1:0] curAddr,
  output logic              isLast,
  output logic              isRowEnd
);
  localparam int EXT_W = ADDR_W - CNT_W;

  logic [CNT_W-1:0]  xLeft, yLeft;
  logic [ADDR_W-1:0] xStep, yStep;

  assign xStep    = {{EXT_W{xMod[CNT_W-1]}}, xMod};
  assign yStep    = {{EXT_W{yMod[CNT_W-1]}}, yMod};
  assign isRowEnd = (xLeft == CNT_W'(1));
  assign isLast   = isRowEnd && (!mode2D || yLeft == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      xLeft   <= '0;
      yLeft   <= '0;
    end else if (load) begin
      curAddr <= startAddr;
      xLeft   <= xCount;
      yLeft   <= yCount;
    end else if (step) begin
      if (mode2D && isRowEnd) begin
        curAddr <= curAddr + yStep;
        xLeft   <= xCount;
        yLeft   <= yLeft - CNT_W'(1);
      end else begin
        curAddr <= curAddr + xStep;
        xLeft   <= xLeft - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dmaStatusT        st,
  input  logic [LVL_W-1:0] fifoLevel,
  output dmaStrobeT        strb
);
  logic bothOn, anyErr, srcRun, dstRun;
  logic badWidth, srcMis, dstMis, fault, room;
  logic srcIssue, dstWrite, irqEnd, irqRow;

  always_comb begin
    bothOn   = st.srcEn && st.dstEn;
    anyErr   = st.srcErr || st.dstErr;
    srcRun   = bothOn && !st.srcDone && !anyErr;
    dstRun   = bothOn && !st.dstDone && !anyErr;
    badWidth = (st.srcWidth != st.dstWidth) || (st.srcWidth == EW_RSV);
    srcMis   = srcRun && ((st.srcLow & alignMask(st.srcWidth)) != 2'b00);
    dstMis   = dstRun && ((st.dstLow & alignMask(st.dstWidth)) != 2'b00);
    fault    = (srcRun || dstRun) && (badWidth || srcMis || dstMis);
    room     = (int'(fifoLevel) + int'(st.rdPend)) < FIFO_DEPTH;
    srcIssue = srcRun && !fault && room;
    dstWrite = dstRun && !fault && (fifoLevel != '0);
    irqEnd   = st.dstLast && ((!st.dst2D && st.dstIrqX) || (st.dst2D && st.dstIrqY));
    irqRow   = st.dst2D && st.dstIrqX && st.dstRowEnd;

    strb.srcIssue   = srcIssue;
    strb.dstWrite   = dstWrite;
    strb.srcDoneSet = srcIssue && st.srcLast;
    strb.dstDoneSet = dstWrite && st.dstLast;
    strb.errSet     = fault;
    strb.irqSet     = dstWrite && (irqEnd || irqRow);
  end

  // R2: no traffic unless both channels are enabled
  a_r2_both_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (strb.srcIssue || strb.dstWrite) |-> (st.srcEn && st.dstEn));

  // R10: a read is never issued into a full buffer
  a_r10_no_read_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == LVL_W'(FIFO_DEPTH)) |-> !strb.srcIssue);

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int PTR_W = $clog2(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  dmaStrobeT         strb,
  output dmaStatusT         st,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              srcRe,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [1:0]        srcSize,
  input  logic [31:0]       srcRdata,
  output logic              dstWe,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [1:0]        dstSize,
  output logic [31:0]       dstWdata,
  output logic              dmaIrq
);
  logic [ADDR_W-1:0] startQ [2];
  logic [CNT_W-1:0]  xCntQ  [2];
  logic [CNT_W-1:0]  xModQ  [2];
  logic [CNT_W-1:0]  yCntQ  [2];
  logic [CNT_W-1:0]  yModQ  [2];
  logic [6:0]        cfgQ   [2];
  logic              doneQ  [2];
  logic              errQ   [2];

  logic [ADDR_W-1:0] walkAddr   [2];
  logic              walkLast   [2];
  logic              walkRowEnd [2];

  logic chSel;
  logic [2:0] rgSel;
  logic cfgWr [2];
  logic clrWr [2];
  logic statWr [2];
  logic loadCh [2];
  logic stepCh [2];
  logic doneSet [2];
  logic flushReq;

  assign chSel = regAddr[3];
  assign rgSel = regAddr[2:0];

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      cfgWr[c]  = regWe && (chSel == 1'(c)) && (rgSel == RG_CFG);
      statWr[c] = regWe && (chSel == 1'(c)) && (rgSel == RG_STAT);
      clrWr[c]  = cfgWr[c] && regWrData[CF_CLR];
      loadCh[c] = cfgWr[c] && regWrData[CF_EN] && !regWrData[CF_CLR] && !cfgQ[c][CF_EN];
    end
    stepCh[0]  = strb.srcIssue;
    stepCh[1]  = strb.dstWrite;
    doneSet[0] = strb.srcDoneSet;
    doneSet[1] = strb.dstDoneSet;
    flushReq   = clrWr[0] || clrWr[1];
  end

  // register bank for both channels
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        startQ[c] <= '0;
        xCntQ[c]  <= '0;
        xModQ[c]  <= '0;
        yCntQ[c]  <= '0;
        yModQ[c]  <= '0;
        cfgQ[c]   <= '0;
        doneQ[c]  <= 1'b0;
        errQ[c]   <= 1'b0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (regWe && chSel == 1'(c)) begin
          case (rgSel)
            RG_START: startQ[c] <= regWrData[ADDR_W-1:0];
            RG_XCNT:  xCntQ[c]  <= regWrData[CNT_W-1:0];
            RG_XMOD:  xModQ[c]  <= regWrData[CNT_W-1:0];
            RG_YCNT:  yCntQ[c]  <= regWrData[CNT_W-1:0];
            RG_YMOD:  yModQ[c]  <= regWrData[CNT_W-1:0];
            RG_CFG:   cfgQ[c]   <= clrWr[c] ? {regWrData[6:1], 1'b0} : regWrData[6:0];
            default:  ;
          endcase
        end
        doneQ[c] <= doneSet[c] || (doneQ[c] && !(statWr[c] && regWrData[0]));
        errQ[c]  <= strb.errSet || (errQ[c] && !(statWr[c] && regWrData[1]));
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : gWalk
    dma_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
      .clk      (clk),
      .rstN     (rstN),
      .load     (loadCh[c]),
      .step     (stepCh[c]),
      .mode2D   (cfgQ[c][CF_2D]),
      .startAddr(startQ[c]),
      .xCount   (xCntQ[c]),
      .yCount   (yCntQ[c]),
      .xMod     (xModQ[c]),
      .yMod     (yModQ[c]),
      .curAddr  (walkAddr[c]),
      .isLast   (walkLast[c]),
      .isRowEnd (walkRowEnd[c])
    );
  end

  // element buffer
  logic [DATA_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  levelQ;
  logic              rdPendQ, push, pop, irqQ;

  assign push = rdPendQ;
  assign pop  = strb.dstWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      levelQ  <= '0;
      rdPendQ <= 1'b0;
    end else if (flushReq) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      levelQ  <= '0;
      rdPendQ <= 1'b0;
    end else begin
      rdPendQ <= strb.srcIssue;
      if (push) begin
        fifoMem[wrPtr] <= srcRdata & elemMask(cfgQ[0][CF_WLO+:2]);
        wrPtr <= wrPtr + PTR_W'(1);
      end
      if (pop) rdPtr <= rdPtr + PTR_W'(1);
      levelQ <= levelQ + LVL_W'(push) - LVL_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= strb.irqSet;
  end

  assign fifoLevel = levelQ;
  assign srcRe     = strb.srcIssue;
  assign srcAddr   = walkAddr[0];
  assign srcSize   = cfgQ[0][CF_WLO+:2];
  assign dstWe     = strb.dstWrite;
  assign dstAddr   = walkAddr[1];
  assign dstSize   = cfgQ[1][CF_WLO+:2];
  assign dstWdata  = fifoMem[rdPtr] & elemMask(cfgQ[1][CF_WLO+:2]);
  assign dmaIrq    = irqQ;

  always_comb begin
    st.srcEn     = cfgQ[0][CF_EN];
    st.dstEn     = cfgQ[1][CF_EN];
    st.srcDone   = doneQ[0];
    st.dstDone   = doneQ[1];
    st.srcErr    = errQ[0];
    st.dstErr    = errQ[1];
    st.srcWidth  = cfgQ[0][CF_WLO+:2];
    st.dstWidth  = cfgQ[1][CF_WLO+:2];
    st.srcLow    = walkAddr[0][1:0];
    st.dstLow    = walkAddr[1][1:0];
    st.srcLast   = walkLast[0];
    st.dstLast   = walkLast[1];
    st.dstRowEnd = walkRowEnd[1];
    st.dst2D     = cfgQ[1][CF_2D];
    st.dstIrqX   = cfgQ[1][CF_IRQX];
    st.dstIrqY   = cfgQ[1][CF_IRQY];
    st.rdPend    = rdPendQ;
  end

  always_comb begin
    regRdData = '0;
    case (rgSel)
      RG_START: regRdData = 32'(startQ[chSel]);
      RG_XCNT:  regRdData = 32'(xCntQ[chSel]);
      RG_XMOD:  regRdData = 32'(xModQ[chSel]);
      RG_YCNT:  regRdData = 32'(yCntQ[chSel]);
      RG_YMOD:  regRdData = 32'(yModQ[chSel]);
      RG_CFG:   regRdData = 32'(cfgQ[chSel]);
      RG_STAT:  regRdData = {30'd0, errQ[chSel], doneQ[chSel]};
      default:  regRdData = '0;
    endcase
  end

  // R10: buffer level bounded, writes only from a filled buffer
  a_r10_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    levelQ <= LVL_W'(FIFO_DEPTH));
  a_r10_write_has_data: assert property (@(posedge clk) disable iff (!rstN)
    dstWe |-> (levelQ != '0));
  // R9: a clear leaves the buffer empty
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (levelQ == '0));
  // R7: error flags silence both memory ports
  a_r7_err_silent: assert property (@(posedge clk) disable iff (!rstN)
    (errQ[0] || errQ[1]) |-> (!srcRe && !dstWe));
  // R8: issued source reads are aligned to the element size
  a_r8_src_aligned: assert property (@(posedge clk) disable iff (!rstN)
    srcRe |-> ((srcAddr[1:0] & alignMask(srcSize)) == 2'b00));
  // R5: destination done only follows a write
  a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ[1]) |-> $past(dstWe));
  // R6: one-dimensional completion interrupt accompanies done
  a_r6_irq_with_done: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(doneQ[1]) && !cfgQ[1][CF_2D] && cfgQ[1][CF_IRQX]) |-> irqQ);

endmodule

// File: rtl/dma_pair.sv
module dma_pair
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              srcRe,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [1:0]        srcSize,
  input  logic [31:0]       srcRdata,
  output logic              dstWe,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [1:0]        dstSize,
  output logic [31:0]       dstWdata,
  output logic              dmaIrq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  dmaStrobeT        strb;
  dmaStatusT        st;
  logic [LVL_W-1:0] fifoLevel;

  dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .strb(strb), .st(st), .fifoLevel(fifoLevel),
    .srcRe(srcRe), .srcAddr(srcAddr), .srcSize(srcSize), .srcRdata(srcRdata),
    .dstWe(dstWe), .dstAddr(dstAddr), .dstSize(dstSize), .dstWdata(dstWdata),
    .dmaIrq(dmaIrq)
  );

  dma_control #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .st(st), .fifoLevel(fifoLevel), .strb(strb)
  );

endmodule

// File: tb/sim_dma_pair.sv
module sim_dma_pair;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        srcRe, dstWe, dmaIrq;
  logic [31:0] srcAddr, dstAddr, dstWdata;
  logic [31:0] srcRdata = '0;
  logic [1:0]  srcSize, dstSize;

  always #5 clk = ~clk;

  dma_pair u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .srcRe(srcRe), .srcAddr(srcAddr), .srcSize(srcSize),
    .srcRdata(srcRdata), .dstWe(dstWe), .dstAddr(dstAddr), .dstSize(dstSize),
    .dstWdata(dstWdata), .dmaIrq(dmaIrq)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0] mem [0:4095];

  function automatic logic [31:0] memRd(input logic [31:0] a, input logic [1:0] w);
    logic [31:0] v = '0;
    int n = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    for (int i = 0; i < n; i++) v[8*i +: 8] = mem[(a + 32'(i)) & 32'hfff];
    return v;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (srcRe) srcRdata <= memRd(srcAddr, srcSize);
    if (dstWe) begin
      for (int i = 0; i < ((dstSize == 2'd0) ? 1 : (dstSize == 2'd1) ? 2 : 4); i++)
        mem[(dstAddr + 32'(i)) & 32'hfff] <= dstWdata[8*i +: 8];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [31:0] a; logic [31:0] d; logic [1:0] w; } expT;
  expT   q[$];
  string curTag = "R2";
  int rdIssued = 0, wrDone = 0, maxAhead = 0, irqCnt = 0, irqCyc = 0, lastWeCyc = 0;

  always @(negedge clk) begin
    expT e;
    if (rstN) begin
      if (srcRe) rdIssued++;
      if (dstWe) begin
        wrDone++;
        lastWeCyc = cyc;
        if (q.size() == 0) check(1'b0, {curTag, " unexpected write"}, dstAddr, 32'hx);
        else begin
          e = q.pop_front();
          check(dstAddr == e.a, {curTag, " write address"}, dstAddr, e.a);
          check(dstWdata == e.d && dstSize == e.w, {curTag, " write data"}, dstWdata, e.d);
        end
      end
      if (rdIssued - wrDone > maxAhead) maxAhead = rdIssued - wrDone;
      if (dmaIrq) begin irqCnt++; irqCyc = cyc; end
    end
  end

  task automatic regWrite(input bit ch, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = {ch, sel}; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input bit ch, input logic [2:0] sel, output logic [31:0] v);
    @(negedge clk);
    regAddr = {ch, sel};
    #1 v = regRdData;
  endtask

  task automatic progChan(input bit ch, input logic [31:0] s, input logic [15:0] xc,
                          input logic [15:0] xm, input logic [15:0] yc, input logic [15:0] ym);
    regWrite(ch, 3'd6, 32'h3);
    regWrite(ch, 3'd5, 32'h0);
    regWrite(ch, 3'd0, s);
    regWrite(ch, 3'd1, {16'd0, xc});
    regWrite(ch, 3'd2, {16'd0, xm});
    regWrite(ch, 3'd3, {16'd0, yc});
    regWrite(ch, 3'd4, {16'd0, ym});
  endtask

  task automatic resetCounters();
    rdIssued = 0; wrDone = 0; irqCnt = 0; irqCyc = 0; lastWeCyc = 0;
  endtask

  // driver: pushes the expected write sequence, then programs both channels
  task automatic startCopy(input string tag, input logic [31:0] sS, input logic [15:0] sXm,
                           input logic [15:0] sYm, input logic [31:0] dS, input logic [15:0] dXm,
                           input logic [15:0] dYm, input int xc, input int yc, input logic [1:0] w,
                           input bit is2D, input bit irqX, input bit irqY);
    logic [31:0] sa = sS, da = dS;
    int rows = is2D ? yc : 1;
    expT e;
    curTag = tag;
    for (int y = 0; y < rows; y++) begin
      for (int x = 0; x < xc; x++) begin
        e.a = da; e.d = memRd(sa, w); e.w = w;
        q.push_back(e);
        if (is2D && x == xc - 1) begin
          sa = sa + {{16{sYm[15]}}, sYm}; da = da + {{16{dYm[15]}}, dYm};
        end else begin
          sa = sa + {{16{sXm[15]}}, sXm}; da = da + {{16{dXm[15]}}, dXm};
        end
      end
    end
    progChan(1'b0, sS, 16'(xc), sXm, 16'(yc), sYm);
    progChan(1'b1, dS, 16'(xc), dXm, 16'(yc), dYm);
    resetCounters();
    regWrite(1'b0, 3'd5, {25'd0, irqY, irqX, w, is2D, 1'b0, 1'b1});
    regWrite(1'b1, 3'd5, {25'd0, irqY, irqX, w, is2D, 1'b1, 1'b1});
  endtask

  task automatic waitDone(input string tag);
    logic [31:0] v = '0;
    int n = 0;
    while (!v[0] && n < 3000) begin regRead(1'b1, 3'd6, v); n++; end
    repeat (2) @(negedge clk);
    check(v[0] == 1'b1, {tag, " dst done"}, v, 32'h1);
    check(q.size() == 0, {tag, " all writes seen"}, 32'(q.size()), 32'h0);
  endtask

  task automatic stopBoth();
    regWrite(1'b0, 3'd5, 32'h0);
    regWrite(1'b1, 3'd5, 32'h0);
    regWrite(1'b0, 3'd6, 32'h3);
    regWrite(1'b1, 3'd6, 32'h3);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int snapW, snapR;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int ch = 0; ch < 2; ch++)
      for (int s = 0; s < 7; s++) begin
        regRead(1'(ch), 3'(s), v);
        check(v == 32'h0, "R1 reset register", v, 32'h0);
      end
    check({srcRe, dstWe, dmaIrq} == 3'b000, "R1 idle ports", {29'd0, srcRe, dstWe, dmaIrq}, 32'h0);

    // R1 readback
    regWrite(1'b0, 3'd0, 32'h1234_5678);
    regRead(1'b0, 3'd0, v); check(v == 32'h1234_5678, "R1 start readback", v, 32'h1234_5678);
    regWrite(1'b0, 3'd2, 32'h0000_fffc);
    regRead(1'b0, 3'd2, v); check(v == 32'h0000_fffc, "R1 step readback", v, 32'h0000_fffc);
    regWrite(1'b1, 3'd5, 32'h0000_00f6);
    regRead(1'b1, 3'd5, v); check(v == 32'h0000_0076, "R1 config readback", v, 32'h76);
    regWrite(1'b1, 3'd5, 32'h0);

    // R2 only one channel enabled: no traffic
    progChan(1'b0, 32'h100, 16'd4, 16'd1, 16'd1, 16'd0);
    resetCounters();
    regWrite(1'b0, 3'd5, 32'h1);
    repeat (10) @(negedge clk);
    check(rdIssued == 0, "R2 no reads with one channel on", 32'(rdIssued), 32'h0);
    regWrite(1'b0, 3'd5, 32'h0);

    // R2 R5 R6 one-dimensional 32-bit upward copy with completion interrupt
    startCopy("R2", 32'h100, 16'd4, 16'd0, 32'h800, 16'd4, 16'd0, 8, 1, 2'd2, 1'b0, 1'b1, 1'b0);
    waitDone("R2");
    check(irqCnt == 1, "R6 one interrupt", 32'(irqCnt), 32'h1);
    check(irqCyc == lastWeCyc + 1, "R6 interrupt with done", 32'(irqCyc), 32'(lastWeCyc + 1));
    regRead(1'b0, 3'd6, v); check(v == 32'h1, "R5 src done", v, 32'h1);
    regWrite(1'b1, 3'd6, 32'h0);
    regRead(1'b1, 3'd6, v); check(v == 32'h1, "R5 zero write keeps done", v, 32'h1);
    regWrite(1'b1, 3'd6, 32'h1);
    regRead(1'b1, 3'd6, v); check(v == 32'h0, "R5 one write clears done", v, 32'h0);
    stopBoth();

    // R2 8-bit odd addresses, then 16-bit with a wider destination stride
    startCopy("R2", 32'h203, 16'd1, 16'd0, 32'h905, 16'd1, 16'd0, 5, 1, 2'd0, 1'b0, 1'b0, 1'b0);
    waitDone("R2");
    check(irqCnt == 0, "R6 no interrupt when disabled", 32'(irqCnt), 32'h0);
    stopBoth();
    startCopy("R2", 32'h240, 16'd2, 16'd0, 32'h940, 16'd4, 16'd0, 6, 1, 2'd1, 1'b0, 1'b0, 1'b0);
    waitDone("R2");
    stopBoth();

    // R3 downward 16-bit copy
    startCopy("R3", 32'h2fe, 16'hfffe, 16'd0, 32'hafe, 16'hfffe, 16'd0, 6, 1, 2'd1, 1'b0, 1'b1, 1'b0);
    waitDone("R3");
    stopBoth();

    // R4 R6 two-dimensional with end-of-transfer interrupt
    startCopy("R4", 32'h300, 16'd4, 16'd20, 32'hb00, 16'd4, 16'd4, 3, 4, 2'd2, 1'b1, 1'b0, 1'b1);
    waitDone("R4");
    check(irqCnt == 1, "R6 2D single interrupt", 32'(irqCnt), 32'h1);
    stopBoth();

    // R4 R6 two-dimensional 8-bit, negative row step, per-row interrupt
    startCopy("R4", 32'h440, 16'd1, 16'hfff0, 32'hc00, 16'd1, 16'd1, 4, 3, 2'd0, 1'b1, 1'b1, 1'b0);
    waitDone("R4");
    check(irqCnt == 3, "R6 per-row interrupts", 32'(irqCnt), 32'h3);
    stopBoth();

    // R7 width mismatch
    progChan(1'b0, 32'h100, 16'd4, 16'd4, 16'd1, 16'd0);
    progChan(1'b1, 32'h800, 16'd4, 16'd4, 16'd1, 16'd0);
    resetCounters();
    regWrite(1'b0, 3'd5, 32'h11);
    regWrite(1'b1, 3'd5, 32'h0b);
    repeat (5) @(negedge clk);
    regRead(1'b0, 3'd6, v); check(v == 32'h2, "R7 src err on width mismatch", v, 32'h2);
    regRead(1'b1, 3'd6, v); check(v == 32'h2, "R7 dst err on width mismatch", v, 32'h2);
    check(rdIssued == 0 && wrDone == 0, "R7 no traffic", 32'(rdIssued + wrDone), 32'h0);
    stopBoth();
    regRead(1'b0, 3'd6, v); check(v == 32'h0, "R5 err cleared by one write", v, 32'h0);

    // R7 reserved width on both
    resetCounters();
    regWrite(1'b0, 3'd5, 32'h19);
    regWrite(1'b1, 3'd5, 32'h1b);
    repeat (5) @(negedge clk);
    regRead(1'b1, 3'd6, v); check(v == 32'h2, "R7 err on reserved width", v, 32'h2);
    check(rdIssued == 0, "R7 no reads on reserved width", 32'(rdIssued), 32'h0);
    stopBoth();

    // R8 misaligned source
    progChan(1'b0, 32'h102, 16'd4, 16'd4, 16'd1, 16'd0);
    progChan(1'b1, 32'h800, 16'd4, 16'd4, 16'd1, 16'd0);
    resetCounters();
    regWrite(1'b0, 3'd5, 32'h11);
    regWrite(1'b1, 3'd5, 32'h13);
    repeat (5) @(negedge clk);
    regRead(1'b0, 3'd6, v); check(v == 32'h2, "R8 err on misaligned address", v, 32'h2);
    check(rdIssued == 0 && wrDone == 0, "R8 no traffic", 32'(rdIssued + wrDone), 32'h0);
    stopBoth();

    // R9 abort with buffer clear, then a fresh copy
    startCopy("R9", 32'h600, 16'd4, 16'd0, 32'he00, 16'd4, 16'd0, 40, 1, 2'd2, 1'b0, 1'b0, 1'b0);
    repeat (8) @(negedge clk);
    regWrite(1'b1, 3'd5, 32'h80);
    snapW = wrDone; snapR = rdIssued;
    repeat (20) @(negedge clk);
    check(wrDone == snapW, "R9 writes stop after clear", 32'(wrDone), 32'(snapW));
    check(rdIssued == snapR, "R9 reads stop after clear", 32'(rdIssued), 32'(snapR));
    check(wrDone > 0 && wrDone < 40, "R9 aborted mid-copy", 32'(wrDone), 32'd20);
    regRead(1'b1, 3'd5, v); check(v[0] == 1'b0, "R9 enable cleared", v, 32'h0);
    regRead(1'b1, 3'd6, v); check(v == 32'h0, "R9 no done after abort", v, 32'h0);
    q.delete();
    regWrite(1'b0, 3'd5, 32'h80);
    stopBoth();
    startCopy("R9", 32'h500, 16'd4, 16'd0, 32'hd00, 16'd4, 16'd0, 6, 1, 2'd2, 1'b0, 1'b0, 1'b0);
    waitDone("R9");
    stopBoth();

    // R10 read-ahead bound
    check(maxAhead <= 5, "R10 read-ahead bounded", 32'(maxAhead), 32'd5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule